// File: doc/BRIEF.md
# I2C-over-AUX Display Identification Responder

This block answers I2C-over-AUX transactions that a display driver issues on an AUX-style register window. It gives back bytes from a local 128-byte identification memory, with no physical AUX link behind it. The host first writes a request header into data register 1. It then writes the control register with the send-busy bit set.

In that same clock edge the block finishes the transaction. The control register changes to a completion word, and a reply with an ACK code goes into data register 1. Address-only messages open, reset or close a session with the identification target. Single-byte reads then step through the memory from the session's read pointer. If the memory is missing or no target is selected, a read returns the data byte 0xFF. It does not NAK.

A separate write port loads the identification memory, which is laid out for block RAM. Read data for the current pointer is fetched one cycle ahead of use. Register reads come back on `rdata` one cycle after `rd_en`.

Top module: `aux_edid_responder`

## Requirements
- R1: Writes to low address byte 0x14, 0x18, 0x1C, 0x20 or 0x24 (data registers 1 to 5) are stored and read back. Reads of an unmapped offset return 0 and writes to one are dropped.
- R2: A control write (offset 0x10) with bit 31 clear is stored verbatim. It does not touch data register 1 or the session.
- R3: A control write with bit 31 set sends a request. The message size is taken from the written bits 24:20. The header comes from data register 1: opcode in bits 31:28 (bit 28 = read, bit 30 = MOT) and the I2C address in bits 23:8.
- R4: On a send, the control register becomes 0x4020_0000 (DONE at bit 30, size 2) for a read opcode and 0x4010_0000 (size 1) otherwise.
- R5: Size 3 with MOT clear is a stop. It deselects the target, marks the memory unavailable and returns the read pointer to 0.
- R6: Size 3 with MOT set and address 0 resets the session the same way as R5.
- R7: Size 3 with MOT set and address 0x50 selects the target and records memory availability from `monitor_present`. It leaves the read pointer alone. Any other address has no effect.
- R8: A write opcode with a size other than 3 is ignored and acknowledged with data register 1 = 0x0000_0000.
- R9: A read opcode of size 4, with the target selected and available, returns the memory byte at the pointer in bits 23:16 and advances the pointer by one.
- R10: A size-4 read with no target selected or no memory available returns 0x00FF_0000 and does not advance the pointer.
- R11: The pointer stops at 128. Further reads return 0x0000_0000.
- R12: A read opcode with a size other than 3 or 4 leaves data register 1 unchanged. The control register still completes as in R4.
- R13: Every reply written to data register 1 carries the ACK code 0x00 in bits 31:24.
- R14: After reset all registers and `rdata` are 0 and no session is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Low byte of the register offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| monitor_present | input | 1 | A display with identification data is attached |
| rom_we | input | 1 | Identification memory write strobe |
| rom_waddr | input | 7 | Identification memory write address |
| rom_wdata | input | 8 | Identification memory write data |

## Verification
The hardest state to reach is the saturated read pointer. Getting there takes a session reset, a target select, and then 128 size-4 reads, each a header write followed by a send. Only after that do two more reads show the zero-byte ACK.

The bench loads a computed byte pattern into the memory and walks that full sequence. It checks every returned byte against the pattern, then checks the reads past the end. Interleaved stops, address-0 resets, ignored writes and a malformed read length check that the pointer and selection survive or clear exactly as required.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;

  localparam logic [7:0] OFS_CTRL  = 8'h10;
  localparam logic [7:0] OFS_DATA0 = 8'h14;

  localparam int CTRL_BUSY_BIT = 31;
  localparam int CTRL_DONE_BIT = 30;
  localparam int SIZE_LSB      = 20;
  localparam int SIZE_W        = 5;

  localparam logic [SIZE_W-1:0] SIZE_ADDR_ONLY = 5'd3;
  localparam logic [SIZE_W-1:0] SIZE_READ_ONE  = 5'd4;
  localparam logic [SIZE_W-1:0] REPLY_SZ_READ  = 5'd2;
  localparam logic [SIZE_W-1:0] REPLY_SZ_OTHER = 5'd1;

  typedef struct packed {
    logic [3:0]  op;
    logic        is_read;
    logic        mot;
    logic [15:0] i2c_addr;
  } aux_hdr_t;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_RESET  = 2'd1,
    ACT_SELECT = 2'd2,
    ACT_READ   = 2'd3
  } sess_act_e;

endpackage

// File: rtl/aux_hdr_decode.sv
module aux_hdr_decode
  import aux_edid_pkg::*;
#(
  parameter logic [15:0] TARGET_ADDR = 16'h0050
) (
  input  logic [31:0]       req_word,
  input  logic [SIZE_W-1:0] msg_size,
  output aux_hdr_t          hdr,
  output sess_act_e         act,
  output logic              keep_reply
);

  always_comb begin
    hdr.op       = req_word[31:28];
    hdr.is_read  = req_word[28];
    hdr.mot      = req_word[30];
    hdr.i2c_addr = req_word[23:8];
  end

  always_comb begin
    act        = ACT_NONE;
    keep_reply = 1'b0;
    if (msg_size == SIZE_ADDR_ONLY) begin
      if (!hdr.mot || hdr.i2c_addr == 16'h0000) begin
        act = ACT_RESET;
      end else if (hdr.i2c_addr == TARGET_ADDR) begin
        act = ACT_SELECT;
      end
    end else if (hdr.is_read) begin
      if (msg_size == SIZE_READ_ONE) begin
        act = ACT_READ;
      end else begin
        keep_reply = 1'b1;
      end
    end
  end

endmodule

// File: rtl/aux_id_rom.sv
module aux_id_rom #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/aux_edid_session.sv
module aux_edid_session
  import aux_edid_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  sess_act_e     act,
  input  logic          monitor_present,
  input  logic [DW-1:0] rom_q,
  output logic [AW-1:0] rom_raddr,
  output logic [PW-1:0] ptr,
  output logic          selected,
  output logic          available,
  output logic [DW-1:0] byte_out
);

  localparam logic [PW-1:0] PTR_END = PW'(DEPTH);

  logic at_end;
  assign at_end    = (ptr == PTR_END);
  assign rom_raddr = ptr[AW-1:0];

  always_comb begin
    if (!(selected && available)) begin
      byte_out = {DW{1'b1}};
    end else if (at_end) begin
      byte_out = '0;
    end else begin
      byte_out = rom_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      selected  <= 1'b0;
      available <= 1'b0;
    end else if (go) begin
      unique case (act)
        ACT_RESET: begin
          ptr       <= '0;
          selected  <= 1'b0;
          available <= 1'b0;
        end
        ACT_SELECT: begin
          selected  <= 1'b1;
          available <= monitor_present;
        end
        ACT_READ: begin
          if (selected && available && !at_end) begin
            ptr <= ptr + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/aux_edid_responder.sv
module aux_edid_responder
  import aux_edid_pkg::*;
#(
  parameter int          ROM_DEPTH   = 128,
  parameter int          NDATA       = 5,
  parameter logic [15:0] TARGET_ADDR = 16'h0050,
  parameter logic [7:0]  ACK_CODE    = 8'h00,
  localparam int         AW          = $clog2(ROM_DEPTH),
  localparam int         PW          = $clog2(ROM_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          monitor_present,
  input  logic          rom_we,
  input  logic [AW-1:0] rom_waddr,
  input  logic [7:0]    rom_wdata
);

  logic [31:0] ctrl_q;
  logic [31:0] data_q [NDATA];

  // address decode for the data window
  logic [NDATA-1:0] data_hit;
  logic             ctrl_hit;
  assign ctrl_hit = (addr == OFS_CTRL);

  for (genvar k = 0; k < NDATA; k++) begin : g_hit
    assign data_hit[k] = (addr == OFS_DATA0 + 8'(4 * k));
  end

  logic send;
  assign send = wr_en && ctrl_hit && wdata[CTRL_BUSY_BIT];

  aux_hdr_t          hdr;
  sess_act_e         act;
  logic              keep_reply;
  logic [SIZE_W-1:0] msg_size;
  assign msg_size = wdata[SIZE_LSB +: SIZE_W];

  aux_hdr_decode #(.TARGET_ADDR(TARGET_ADDR)) u_dec (
    .req_word   (data_q[0]),
    .msg_size   (msg_size),
    .hdr        (hdr),
    .act        (act),
    .keep_reply (keep_reply)
  );

  logic [AW-1:0] rom_raddr;
  logic [7:0]    rom_q;
  logic [PW-1:0] ptr_w;
  logic          sel_w;
  logic          avail_w;
  logic [7:0]    byte_w;

  aux_id_rom #(.DEPTH(ROM_DEPTH), .DW(8)) u_rom (
    .clk   (clk),
    .we    (rom_we),
    .waddr (rom_waddr),
    .wdata (rom_wdata),
    .raddr (rom_raddr),
    .rdata (rom_q)
  );

  aux_edid_session #(.DEPTH(ROM_DEPTH), .DW(8)) u_sess (
    .clk             (clk),
    .rst             (rst),
    .go              (send),
    .act             (act),
    .monitor_present (monitor_present),
    .rom_q           (rom_q),
    .rom_raddr       (rom_raddr),
    .ptr             (ptr_w),
    .selected        (sel_w),
    .available       (avail_w),
    .byte_out        (byte_w)
  );

  logic [31:0] done_word;
  logic [31:0] reply_word;

  always_comb begin
    done_word = '0;
    done_word[CTRL_DONE_BIT] = 1'b1;
    done_word[SIZE_LSB +: SIZE_W] = hdr.is_read ? REPLY_SZ_READ : REPLY_SZ_OTHER;
    reply_word = {ACK_CODE, 24'h0};
    if (act == ACT_READ) begin
      reply_word[23:16] = byte_w;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (send) begin
      ctrl_q <= done_word;
    end else if (wr_en && ctrl_hit) begin
      ctrl_q <= wdata;
    end
  end

  for (genvar k = 0; k < NDATA; k++) begin : g_data
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          data_q[k] <= '0;
        end else if (send) begin
          if (!keep_reply) begin
            data_q[k] <= reply_word;
          end
        end else if (wr_en && data_hit[k]) begin
          data_q[k] <= wdata;
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) begin
          data_q[k] <= '0;
        end else if (wr_en && data_hit[k]) begin
          data_q[k] <= wdata;
        end
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (ctrl_hit) begin
      rd_mux = ctrl_q;
    end
    for (int k = 0; k < NDATA; k++) begin
      if (data_hit[k]) begin
        rd_mux = data_q[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/aux_edid_responder_chk.sv
module aux_edid_responder_chk #(
  parameter int         DEPTH    = 128,
  parameter logic [7:0] ACK_CODE = 8'h00,
  localparam int        PW       = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [7:0]    addr,
  input logic [31:0]   wdata,
  input logic [31:0]   ctrl,
  input logic [31:0]   d1,
  input logic [PW-1:0] ptr,
  input logic          sel
);

  logic ctl_wr;
  assign ctl_wr = wr_en && (addr == 8'h10);

  a_r4_done_word: assert property (@(posedge clk) disable iff (rst)
    ctl_wr && wdata[31] |=> ctrl[30] && !ctrl[31]);

  a_r2_plain_store: assert property (@(posedge clk) disable iff (rst)
    ctl_wr && !wdata[31] |=> ctrl == $past(wdata));

  a_r5_stop_clears: assert property (@(posedge clk) disable iff (rst)
    ctl_wr && wdata[31] && wdata[24:20] == 5'd3 && !d1[30] |=> !sel && ptr == '0);

  a_r13_ack_code: assert property (@(posedge clk) disable iff (rst)
    ctl_wr && wdata[31] && wdata[24:20] == 5'd3 |=> d1[31:24] == ACK_CODE);

  a_r11_ptr_bound: assert property (@(posedge clk) disable iff (rst)
    ptr <= PW'(DEPTH));

  a_r9_ptr_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ptr == $past(ptr) || ptr == $past(ptr) + 1'b1 || ptr == '0);

endmodule

bind aux_edid_responder aux_edid_responder_chk #(
  .DEPTH    (ROM_DEPTH),
  .ACK_CODE (ACK_CODE)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .wr_en (wr_en),
  .addr  (addr),
  .wdata (wdata),
  .ctrl  (ctrl_q),
  .d1    (data_q[0]),
  .ptr   (ptr_w),
  .sel   (sel_w)
);

// File: tb/aux_edid_responder_tb.sv
module aux_edid_responder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        monitor_present = 1'b1;
  logic        rom_we = 1'b0;
  logic [6:0]  rom_waddr = '0;
  logic [7:0]  rom_wdata = '0;

  int n_cmp = 0;
  int n_bad = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  aux_edid_responder u_dut (
    .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en), .addr (addr),
    .wdata (wdata), .rdata (rdata), .monitor_present (monitor_present),
    .rom_we (rom_we), .rom_waddr (rom_waddr), .rom_wdata (rom_wdata)
  );

  function automatic logic [7:0] rom_val(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // header, control write, expected control, expected data register 1
  localparam int NV = 14;
  localparam logic [127:0] VEC [NV] = '{
    {32'h1000_5000, 32'h8040_0000, 32'h4020_0000, 32'h00FF_0000}, // R10 nothing selected
    {32'h5000_5000, 32'h8030_0000, 32'h4020_0000, 32'h0000_0000}, // R7 select
    {32'h1000_5000, 32'h8040_0000, 32'h4020_0000, 32'h0005_0000}, // R9 byte 0
    {32'h1000_5000, 32'h8040_0000, 32'h4020_0000, 32'h002A_0000}, // R9 byte 1
    {32'h4000_5000, 32'h8020_0000, 32'h4010_0000, 32'h0000_0000}, // R8 write ignored
    {32'h1000_5000, 32'h8040_0000, 32'h4020_0000, 32'h004F_0000}, // R9 byte 2
    {32'h1000_5000, 32'h8030_0000, 32'h4020_0000, 32'h0000_0000}, // R5 stop
    {32'h1000_5000, 32'h8040_0000, 32'h4020_0000, 32'h00FF_0000}, // R5 deselected
    {32'h5000_5000, 32'h8030_0000, 32'h4020_0000, 32'h0000_0000}, // R7 reselect
    {32'h1000_5000, 32'h8040_0000, 32'h4020_0000, 32'h0005_0000}, // R5 pointer back at 0
    {32'h5000_0000, 32'h8030_0000, 32'h4020_0000, 32'h0000_0000}, // R6 address 0
    {32'h1000_5000, 32'h8040_0000, 32'h4020_0000, 32'h00FF_0000}, // R6 session gone
    {32'h4000_3700, 32'h8030_0000, 32'h4010_0000, 32'h0000_0000}, // R7 other address
    {32'h1000_5000, 32'h8040_0000, 32'h4020_0000, 32'h00FF_0000}  // R7 still unselected
  };

  task automatic xact(string req, logic [31:0] h, logic [31:0] c,
                      logic [31:0] ec, logic [31:0] ed);
    logic [31:0] v;
    wr(8'h14, h);
    wr(8'h10, c);
    rd(8'h10, v);
    chk({req, " ctrl"}, v, ec);
    rd(8'h14, v);
    chk({req, " data1"}, v, ed);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R14 reset state
    rd(8'h10, v); chk("R14 ctrl", v, 32'h0);
    rd(8'h14, v); chk("R14 data1", v, 32'h0);

    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      rom_we = 1'b1; rom_waddr = 7'(i); rom_wdata = rom_val(i);
    end
    @(negedge clk);
    rom_we = 1'b0;

    // R1 data window and unmapped offsets
    for (int k = 0; k < 5; k++) begin
      wr(8'(8'h14 + 4 * k), 32'hA5A5_0000 + 32'(k));
    end
    for (int k = 0; k < 5; k++) begin
      rd(8'(8'h14 + 4 * k), v);
      chk("R1 data reg", v, 32'hA5A5_0000 + 32'(k));
    end
    wr(8'h28, 32'hDEAD_BEEF);
    rd(8'h28, v); chk("R1 unmapped read", v, 32'h0);
    rd(8'h18, v); chk("R1 neighbour untouched", v, 32'hA5A5_0001);

    // R2 control write without send-busy
    wr(8'h10, 32'h0012_3456);
    rd(8'h10, v); chk("R2 stored", v, 32'h0012_3456);
    rd(8'h14, v); chk("R2 data1 untouched", v, 32'hA5A5_0000);

    // table walk: R3 R4 R5 R6 R7 R8 R9 R10 R13
    for (int i = 0; i < NV; i++) begin
      xact("R4/R13 vector", VEC[i][127:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);
    end

    // R12 read opcode with a bad length keeps data1
    wr(8'h14, 32'h1000_5000);
    wr(8'h10, 32'h8020_0000);
    rd(8'h10, v); chk("R12 ctrl", v, 32'h4020_0000);
    rd(8'h14, v); chk("R12 data1 kept", v, 32'h1000_5000);

    // R7 select with no monitor leaves the memory unavailable
    monitor_present = 1'b0;
    xact("R7 reset", 32'h5000_0000, 32'h8030_0000, 32'h4020_0000, 32'h0);
    xact("R7 select nomon", 32'h5000_5000, 32'h8030_0000, 32'h4020_0000, 32'h0);
    xact("R7 read nomon", 32'h1000_5000, 32'h8040_0000, 32'h4020_0000, 32'h00FF_0000);
    monitor_present = 1'b1;

    // R11 exhaust the memory
    xact("R11 reset", 32'h5000_0000, 32'h8030_0000, 32'h4020_0000, 32'h0);
    xact("R11 select", 32'h5000_5000, 32'h8030_0000, 32'h4020_0000, 32'h0);
    for (int i = 0; i < 128; i++) begin
      xact("R9 sweep", 32'h1000_5000, 32'h8040_0000, 32'h4020_0000,
           {8'h00, rom_val(i), 16'h0000});
    end
    xact("R11 past end", 32'h1000_5000, 32'h8040_0000, 32'h4020_0000, 32'h0);
    xact("R11 past end again", 32'h1000_5000, 32'h8040_0000, 32'h4020_0000, 32'h0);

    // R14 reset mid-session
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(8'h10, v); chk("R14 ctrl after reset", v, 32'h0);
    xact("R14 no session", 32'h1000_5000, 32'h8040_0000, 32'h4020_0000, 32'h00FF_0000);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule